// File: doc/BRIEF.md
# Nonvolatile SRAM Software Store/Recall Command Detector

This block sits at the pin side of a nonvolatile SRAM and watches ordinary read cycles. A host starts a nonvolatile operation without any dedicated pin. It issues six chip-enable cycles, each with write enable high, and the six addresses must match a fixed sequence. The address in the sixth cycle picks the operation. One value starts a STORE, which copies the SRAM into the nonvolatile array. Another value starts a RECALL, which copies the array back into the SRAM.

The pins are brought into the clock domain through a synchronizer. The detector then treats each rising edge of the synchronized chip enable as the end of one command cycle. On acceptance of the sixth step the block emits a one-clock start pulse for the chosen operation. It then holds `busy` for a fixed, parameterised number of clocks. While busy, the data-bus drive enable stays low, so the bus floats, and every chip-enable cycle is disregarded.

Top module: `nvseq_ctrl`

## Requirements
- R1: After reset, `store_start`, `recall_start`, `busy` and `dq_drive` are all low and the sequence position is at its first step.
- R2: Six accepted chip-enable cycles carrying, in order, 0x0E38, 0x11C7, 0x03E0, 0x1C1F, 0x103F and then an operation code start a nonvolatile operation; a chip-enable cycle ends on the rising edge of the synchronized `ce_n`.
- R3: The operation code 0x0FC0 in the sixth cycle pulses `store_start`, 0x0C63 pulses `recall_start`, and any other sixth address starts nothing.
- R4: A cycle whose address is not the expected one drops the sequence back to its beginning; if that address is 0x0E38 it counts as the first step, so the next expected address is 0x11C7.
- R5: A chip-enable cycle during which `we_n` is sampled low at any time is not a sequence step and resets the sequence to its beginning.
- R6: The level of `oe_n`, high or low, has no effect on the sequence.
- R7: A chip-enable low pulse lasting fewer than `MIN_LOW_CYC` synchronized clocks is disregarded: it neither advances nor resets the sequence. A pulse of exactly `MIN_LOW_CYC` clocks is accepted.
- R8: `store_start` and `recall_start` are never high together and each is high for a single clock per operation.
- R9: `busy` rises in the clock after a start pulse and stays high for exactly `STORE_CYCLES` clocks after a STORE or `RECALL_CYCLES` clocks after a RECALL.
- R10: Chip-enable cycles that end while `busy` is high are disregarded: they start no operation and leave the sequence at its beginning.
- R11: `dq_drive` is high during a synchronized read cycle (`ce_n` low, `oe_n` low, `we_n` high) only while not busy; it is low whenever `busy` is high.
- R12: Once the sixth step is accepted, the operation runs whether `ce_n` then stays high or returns low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable pin, active low, asynchronous to `clk` |
| we_n | input | 1 | Write enable pin, active low |
| oe_n | input | 1 | Output enable pin, active low |
| addr | input | 13 | Address pins |
| store_start | output | 1 | One-clock pulse starting a STORE |
| recall_start | output | 1 | One-clock pulse starting a RECALL |
| busy | output | 1 | High while a nonvolatile operation runs |
| dq_drive | output | 1 | Data bus drive enable; low means the bus is high impedance |

## Verification
The assertions take for granted that `addr` and `we_n` hold their values for the whole low phase of a chip-enable cycle. They also assume every pin level lasts at least one clock, so the synchronizer sees each phase and the latched address belongs to the cycle that ends. The stimulus meets this by changing pins only on falling clock edges. It sets the address and write enable together with the falling chip enable, and keeps them until chip enable has risen. The single deliberate glitch is one clock long and carries its own stable address.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;

  localparam int ADDR_W  = 13;
  localparam int SEQ_LEN = 6;
  localparam int STEP_W  = $clog2(SEQ_LEN);

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [STEP_W-1:0] step_t;

  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_STORE  = 2'd1,
    OP_RECALL = 2'd2
  } nv_op_e;

  typedef struct packed {
    step_t  step;
    nv_op_e op;
  } step_res_t;

  localparam addr_t CODE_STORE  = 13'h0FC0;
  localparam addr_t CODE_RECALL = 13'h0C63;

  // Expected address for the leading five steps of the command
  function automatic addr_t seq_code(input step_t idx);
    case (idx)
      step_t'(0): return 13'h0E38;
      step_t'(1): return 13'h11C7;
      step_t'(2): return 13'h03E0;
      step_t'(3): return 13'h1C1F;
      step_t'(4): return 13'h103F;
      default:    return '0;
    endcase
  endfunction

  // Sequence transition for one accepted chip-enable cycle
  function automatic step_res_t next_step(input step_t cur, input addr_t a,
                                          input logic we_ok);
    step_res_t r;
    r.step = '0;
    r.op   = OP_NONE;
    if (!we_ok) return r;
    if (cur == step_t'(SEQ_LEN - 1)) begin
      if (a == CODE_STORE)         r.op = OP_STORE;
      else if (a == CODE_RECALL)   r.op = OP_RECALL;
      else if (a == seq_code('0))  r.step = step_t'(1);
    end else if (a == seq_code(cur)) begin
      r.step = cur + 1'b1;
    end else if (a == seq_code('0)) begin
      r.step = step_t'(1);
    end
    return r;
  endfunction

  // Length of the busy window for an operation
  function automatic int unsigned busy_len(input nv_op_e op,
                                           input int unsigned store_cyc,
                                           input int unsigned recall_cyc);
    case (op)
      OP_STORE:  return store_cyc;
      OP_RECALL: return recall_cyc;
      default:   return 0;
    endcase
  endfunction

endpackage

// File: rtl/nvseq_pin_sync.sv
module nvseq_pin_sync #(
  parameter int             W       = 16,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= RST_VAL;
          else        stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= RST_VAL;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/nvseq_cycle_qual.sv
module nvseq_cycle_qual
  import nvseq_pkg::*;
#(
  parameter int MIN_LOW = 3
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ce_n_s,
  input  logic  we_n_s,
  input  addr_t addr_s,
  output logic  cycle_end,
  output logic  step_strobe,
  output addr_t step_addr,
  output logic  step_we_ok
);

  localparam int CNT_W = $clog2(MIN_LOW + 1);
  localparam logic [CNT_W-1:0] CNT_MIN = CNT_W'(MIN_LOW);

  logic             ce_prev;
  logic [CNT_W-1:0] low_cnt;
  logic             we_bad;
  addr_t            addr_lat;
  logic             long_enough;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_prev  <= 1'b1;
      low_cnt  <= '0;
      we_bad   <= 1'b0;
      addr_lat <= '0;
    end else begin
      ce_prev <= ce_n_s;
      if (ce_n_s) begin
        low_cnt <= '0;
        we_bad  <= 1'b0;
      end else begin
        if (low_cnt != CNT_MIN) low_cnt <= low_cnt + 1'b1;
        if (!we_n_s) we_bad <= 1'b1;
        addr_lat <= addr_s;
      end
    end
  end

  assign cycle_end   = ce_n_s & ~ce_prev;
  assign long_enough = (low_cnt >= CNT_MIN);
  assign step_strobe = cycle_end & long_enough;
  assign step_addr   = addr_lat;
  assign step_we_ok  = ~we_bad;

  AST_SHORT_PULSE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_end && (low_cnt < CNT_MIN)) |-> !step_strobe);  // R7
  AST_STROBE_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    step_strobe |-> (ce_n_s && !ce_prev));  // R2

endmodule

// File: rtl/nvseq_matcher.sv
module nvseq_matcher
  import nvseq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  step_strobe,
  input  addr_t step_addr,
  input  logic  step_we_ok,
  input  logic  busy,
  output logic  store_start,
  output logic  recall_start,
  output step_t step_idx
);

  step_t     step_q;
  logic      accept;
  step_res_t res;

  assign accept = step_strobe & ~busy;
  assign res    = next_step(step_q, step_addr, step_we_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q       <= '0;
      store_start  <= 1'b0;
      recall_start <= 1'b0;
    end else begin
      if (accept) step_q <= res.step;
      store_start  <= accept && (res.op == OP_STORE);
      recall_start <= accept && (res.op == OP_RECALL);
    end
  end

  assign step_idx = step_q;

  AST_STEP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    step_q <= step_t'(SEQ_LEN - 1));  // R2
  AST_STEP_HOLDS_UNLESS_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(step_q));  // R10
  AST_WE_LOW_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !step_we_ok) |=> (step_q == '0 && !store_start && !recall_start));  // R5
  AST_START_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(store_start && recall_start));  // R8
  AST_STORE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    store_start |=> !store_start);  // R8
  AST_RECALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    recall_start |=> !recall_start);  // R8

endmodule

// File: rtl/nvseq_busy_timer.sv
module nvseq_busy_timer
  import nvseq_pkg::*;
#(
  parameter int STORE_CYC  = 400,
  parameter int RECALL_CYC = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic store_start,
  input  logic recall_start,
  output logic busy
);

  localparam int MAX_CYC = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
  localparam int CW      = $clog2(MAX_CYC + 1);

  logic [CW-1:0] cnt;
  logic          load;
  nv_op_e        op;

  assign load = store_start | recall_start;
  assign op   = store_start ? OP_STORE : (recall_start ? OP_RECALL : OP_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= CW'(busy_len(op, STORE_CYC, RECALL_CYC));
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  AST_BUSY_FOLLOWS_START: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy);  // R9
  AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !load);  // R10

endmodule

// File: rtl/nvseq_ctrl.sv
module nvseq_ctrl
  import nvseq_pkg::*;
#(
  parameter int MIN_LOW_CYC   = 3,
  parameter int STORE_CYCLES  = 400,
  parameter int RECALL_CYCLES = 250,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              store_start,
  output logic              recall_start,
  output logic              busy,
  output logic              dq_drive
);

  localparam int PIN_W = ADDR_W + 3;
  localparam logic [PIN_W-1:0] PIN_IDLE = {3'b111, {ADDR_W{1'b0}}};

  logic [PIN_W-1:0] pins_s;
  logic             ce_n_s, we_n_s, oe_n_s;
  addr_t            addr_s;

  // Event wires between the stages
  logic  cycle_end;
  logic  step_strobe;
  addr_t step_addr;
  logic  step_we_ok;
  step_t step_idx;

  nvseq_pin_sync #(
    .W       (PIN_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (PIN_IDLE)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({ce_n, we_n, oe_n, addr}),
    .q     (pins_s)
  );

  assign {ce_n_s, we_n_s, oe_n_s, addr_s} = pins_s;

  nvseq_cycle_qual #(
    .MIN_LOW (MIN_LOW_CYC)
  ) u_qual (
    .clk         (clk),
    .rst_n       (rst_n),
    .ce_n_s      (ce_n_s),
    .we_n_s      (we_n_s),
    .addr_s      (addr_s),
    .cycle_end   (cycle_end),
    .step_strobe (step_strobe),
    .step_addr   (step_addr),
    .step_we_ok  (step_we_ok)
  );

  nvseq_matcher u_match (
    .clk          (clk),
    .rst_n        (rst_n),
    .step_strobe  (step_strobe),
    .step_addr    (step_addr),
    .step_we_ok   (step_we_ok),
    .busy         (busy),
    .store_start  (store_start),
    .recall_start (recall_start),
    .step_idx     (step_idx)
  );

  nvseq_busy_timer #(
    .STORE_CYC  (STORE_CYCLES),
    .RECALL_CYC (RECALL_CYCLES)
  ) u_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .store_start  (store_start),
    .recall_start (recall_start),
    .busy         (busy)
  );

  assign dq_drive = ~busy & ~ce_n_s & ~oe_n_s & we_n_s;

  AST_HIZ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !dq_drive);  // R11
  AST_START_LEAVES_STEP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (store_start || recall_start) |-> (step_idx == '0));  // R12
  AST_CYCLE_END_WHILE_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_end && busy) |=> (!store_start && !recall_start));  // R10

endmodule

// File: tb/nvseq_ctrl_tb.sv
module nvseq_ctrl_tb;

  localparam int MIN_LOW = 3;
  localparam int ST_CYC  = 400;
  localparam int RC_CYC  = 250;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [12:0] addr = '0;
  logic        store_start, recall_start, busy, dq_drive;

  int n_chk = 0;
  int n_fail = 0;
  int exp_q[$];
  int pulses = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  nvseq_ctrl #(
    .MIN_LOW_CYC   (MIN_LOW),
    .STORE_CYCLES  (ST_CYC),
    .RECALL_CYCLES (RC_CYC),
    .SYNC_STAGES   (2)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .ce_n (ce_n), .we_n (we_n), .oe_n (oe_n),
    .addr (addr), .store_start (store_start), .recall_start (recall_start),
    .busy (busy), .dq_drive (dq_drive)
  );

  function automatic logic [12:0] cmd(input int i);
    logic [12:0] tbl [5] = '{13'h0E38, 13'h11C7, 13'h03E0, 13'h1C1F, 13'h103F};
    return tbl[i];
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Monitor: pops expected operations and measures busy windows
  bit meas = 1'b0;
  int blen = 0, bexp = 0;
  bit prev_pulse = 1'b0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (store_start && recall_start)
        check(1'b0, "R8", "both start pulses", 1, 0);
      if (prev_pulse && (store_start || recall_start))
        check(1'b0, "R8", "start pulse longer than one clock", 2, 1);
      if (store_start || recall_start) begin
        int got;
        got = store_start ? 1 : 2;
        pulses++;
        if (exp_q.size() == 0) check(1'b0, "R3", "unexpected start", got, 0);
        else begin
          int e;
          e = exp_q.pop_front();
          check(got == e, "R3", "operation kind", got, e);
        end
        check(!busy, "R9", "busy in pulse cycle", int'(busy), 0);
        meas = 1'b1;
        blen = 0;
        bexp = (got == 1) ? ST_CYC : RC_CYC;
      end else if (meas) begin
        if (busy) blen++;
        else begin
          check(blen == bexp, "R9", "busy length", blen, bexp);
          meas = 1'b0;
        end
      end
      prev_pulse = store_start || recall_start;
    end
  end

  task automatic ce_cycle(input logic [12:0] a, input bit we_low, input bit oe_low,
                          input int low, input int high);
    @(negedge clk);
    addr = a; we_n = ~we_low; oe_n = ~oe_low; ce_n = 1'b0;
    repeat (low) @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    repeat (high) @(negedge clk);
  endtask

  // Driver: five fixed steps then the operation address; pushes expectation
  task automatic send_seq(input logic [12:0] last, input int exp_op, input int low,
                          input bit oe_alt, input int last_high);
    for (int i = 0; i < 5; i++) ce_cycle(cmd(i), 1'b0, oe_alt && i[0], low, 4);
    if (exp_op != 0) exp_q.push_back(exp_op);
    ce_cycle(last, 1'b0, oe_alt, low, last_high);
  endtask

  task automatic settle(input string req);
    repeat (12) @(negedge clk);
    check(exp_q.size() == 0, req, "expected start not seen", exp_q.size(), 0);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy || meas) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    check(1'b0, "WDOG", "watchdog expired", 1, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int p0;
    repeat (5) @(negedge clk);
    // R1: reset state
    check(!store_start && !recall_start, "R1", "start pulses in reset",
          int'(store_start) + int'(recall_start), 0);
    check(!busy && !dq_drive, "R1", "busy/dq_drive in reset", int'(busy) + int'(dq_drive), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy, "R1", "busy after reset", int'(busy), 0);

    // R2 R3: store then recall
    send_seq(13'h0FC0, 1, 6, 1'b0, 4); settle("R2"); wait_idle();
    send_seq(13'h0C63, 2, 6, 1'b0, 4); settle("R3"); wait_idle();

    // R3: bad sixth address
    p0 = pulses;
    send_seq(13'h0123, 0, 6, 1'b0, 4); settle("R3");
    check(pulses == p0, "R3", "start after bad sixth address", pulses - p0, 0);

    // R4: abort in the middle, then remaining steps alone start nothing
    p0 = pulses;
    ce_cycle(cmd(0), 0, 0, 6, 4); ce_cycle(cmd(1), 0, 0, 6, 4);
    ce_cycle(13'h0555, 0, 0, 6, 4);
    ce_cycle(cmd(2), 0, 0, 6, 4); ce_cycle(cmd(3), 0, 0, 6, 4);
    ce_cycle(cmd(4), 0, 0, 6, 4); ce_cycle(13'h0FC0, 0, 0, 6, 4);
    settle("R4");
    check(pulses == p0, "R4", "start after aborted sequence", pulses - p0, 0);

    // R4: wrong address equal to the first code restarts at step two
    ce_cycle(cmd(0), 0, 0, 6, 4); ce_cycle(cmd(1), 0, 0, 6, 4);
    send_seq(13'h0C63, 2, 6, 1'b0, 4); settle("R4"); wait_idle();

    // R5: write-enable low during step three
    p0 = pulses;
    ce_cycle(cmd(0), 0, 0, 6, 4); ce_cycle(cmd(1), 0, 0, 6, 4);
    ce_cycle(cmd(2), 1, 0, 6, 4);
    ce_cycle(cmd(3), 0, 0, 6, 4); ce_cycle(cmd(4), 0, 0, 6, 4);
    ce_cycle(13'h0FC0, 0, 0, 6, 4);
    settle("R5");
    check(pulses == p0, "R5", "start after write-enable-low step", pulses - p0, 0);

    // R6: output enable toggling during the sequence
    send_seq(13'h0FC0, 1, 6, 1'b1, 4); settle("R6"); wait_idle();

    // R7: one-clock glitch with wrong address is ignored
    ce_cycle(cmd(0), 0, 0, 6, 4); ce_cycle(cmd(1), 0, 0, 6, 4); ce_cycle(cmd(2), 0, 0, 6, 4);
    ce_cycle(13'h1ABC, 0, 0, 1, 4);
    ce_cycle(cmd(3), 0, 0, 6, 4); ce_cycle(cmd(4), 0, 0, 6, 4);
    exp_q.push_back(2);
    ce_cycle(13'h0C63, 0, 0, 6, 4);
    settle("R7"); wait_idle();
    // R7: pulses of exactly the minimum width are accepted
    send_seq(13'h0FC0, 1, MIN_LOW, 1'b0, 4); settle("R7");

    // R10: a full recall sequence during the store busy window is ignored
    p0 = pulses;
    send_seq(13'h0C63, 0, 6, 1'b0, 4);
    repeat (12) @(negedge clk);
    check(pulses == p0, "R10", "start while busy", pulses - p0, 0);
    check(busy, "R10", "busy during ignored sequence", int'(busy), 1);
    // R11: read cycle while busy keeps the bus floating
    @(negedge clk); addr = 13'h0100; oe_n = 1'b0; ce_n = 1'b0;
    repeat (4) @(negedge clk);
    check(!dq_drive, "R11", "dq_drive while busy", int'(dq_drive), 0);
    ce_cycle(13'h0100, 0, 0, 0, 4);
    wait_idle();
    // R10: the steps seen while busy left no progress behind
    p0 = pulses;
    ce_cycle(cmd(3), 0, 0, 6, 4); ce_cycle(cmd(4), 0, 0, 6, 4); ce_cycle(13'h0C63, 0, 0, 6, 4);
    settle("R10");
    check(pulses == p0, "R10", "progress kept from busy window", pulses - p0, 0);

    // R11: normal read drives the bus when idle
    @(negedge clk); addr = 13'h0100; oe_n = 1'b0; ce_n = 1'b0;
    repeat (4) @(negedge clk);
    check(dq_drive, "R11", "dq_drive on idle read", int'(dq_drive), 1);
    ce_n = 1'b1; oe_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!dq_drive, "R11", "dq_drive after read", int'(dq_drive), 0);

    // R12: chip enable returns low right after the sixth step
    send_seq(13'h0FC0, 1, 6, 1'b0, 0);
    ce_cycle(13'h0042, 0, 0, 30, 4);
    settle("R12"); wait_idle();

    check(exp_q.size() == 0, "R2", "pending expectations at end", exp_q.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule